// File: doc/BRIEF.md
# Packed Lane Shifter with Bank-Typed Operands

This unit shifts every lane of a 32-bit register value by the same amount in one pass. The register number of the source operand sets how the word is split and how lanes are treated. Registers in the low bank hold four 8-bit lanes. Registers in the upper bank hold two 16-bit lanes. Each bank has a signed half and an unsigned half. The opcode never carries the lane width.

Three shift kinds are supported: arithmetic right, logical right and logical left. The amount comes from a second register or from an 8-bit immediate. A two-bit mode field selects how the result is shaped and which lanes are written:

- One mode code forces rounding on right shifts and saturation on left shifts.
- The other codes use two global enables instead.
- Two codes also gate lanes with a predicate word or with its complement.

Lanes that are masked off, illegal register numbers and the reserved opcode all pass the old destination value through. The result is registered, so it appears one cycle after the request.

Top module: `simd_lane_shifter`

## Requirements
- R1: Lanes are typed by `src_idx`. Registers 2–7 hold signed 8-bit lanes and 8–15 hold unsigned 8-bit lanes. Registers 16–23 hold signed 16-bit lanes and 24–29 hold unsigned 16-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R2: `op_sel` selects the shift. 00 is arithmetic right, filling from the lane MSB. 01 is logical right, filling with zeros. 10 is logical left, filling with zeros.
- R3: The amount is `imm8` when `use_imm`=1 and `amt_val[7:0]` otherwise. Only the low 3 bits count for 8-bit lanes and the low 4 bits for 16-bit lanes. Every lane uses the same amount.
- R4: With rounding active and a nonzero amount s, a right shift adds input bit s-1 of the lane to the truncated result.
- R5: With saturation active, a left shift that loses significant bits clamps the lane. A signed lane clamps to the most positive value if the input is non-negative and to the most negative value otherwise. An unsigned lane clamps to all ones. Right shifts are not affected by saturation.
- R6: Mode 01 forces both rounding and saturation. Modes 00, 10 and 11 take rounding from `glb_round` and saturation from `glb_sat`.
- R7: In mode 10 a lane is written when the LSB of the matching lane of `pred` is 1. In mode 11 it is written when that LSB is 0. A lane that is not written takes the matching bits of `old_dst`. Modes 00 and 01 write every lane.
- R8: A `src_idx` outside 2–29, or `op_sel`=11, gives a result equal to `old_dst`.
- R9: `out_valid` and `result` update one cycle after `in_valid`. When `in_valid` is low, `out_valid` falls on the next cycle and `result` holds its value.
- R10: During synchronous reset `out_valid` is 0 and `result` is 0.
- R11: A shift amount of zero after the modulo in R3 returns the source lane unchanged, even with rounding and saturation active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Shift kind |
| use_imm | input | 1 | Take amount from immediate |
| imm8 | input | 8 | Immediate shift amount |
| src_idx | input | 5 | Register number of the source |
| src_val | input | 32 | Source value |
| amt_val | input | 32 | Shift-amount register value |
| mode | input | 2 | Mode field |
| pred | input | 32 | Predicate word |
| glb_round | input | 1 | Global rounding enable |
| glb_sat | input | 1 | Global saturation enable |
| old_dst | input | 32 | Previous destination value |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Registered result |

## Verification
Predicate masking and the shaping of the result (rounding or saturation) can act in the same cycle. In modes 10 and 11 the global enables stay live while some lanes are masked off. The bench provokes this with a complemented-predicate, globally rounded arithmetic right shift. It expects the enabled lanes to show the rounded value and the masked lanes to show the old destination bytes, all in one result word. A second case combines a predicate that enables every lane with global saturation on unsigned bytes, and expects every lane clamped to all ones.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;
    localparam int AMT_W  = 8;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    localparam logic [IDX_W-1:0] BYTE_FIRST   = 5'd2;
    localparam logic [IDX_W-1:0] BYTE_U_FIRST = 5'd8;
    localparam logic [IDX_W-1:0] BYTE_LAST    = 5'd15;
    localparam logic [IDX_W-1:0] HALF_FIRST   = 5'd16;
    localparam logic [IDX_W-1:0] HALF_U_FIRST = 5'd24;
    localparam logic [IDX_W-1:0] HALF_LAST    = 5'd29;

    typedef enum logic [1:0] {
        OP_SRA = 2'b00,
        OP_SRL = 2'b01,
        OP_SLL = 2'b10,
        OP_RSV = 2'b11
    } shf_op_e;

    typedef enum logic [1:0] {
        MD_GLOBAL = 2'b00,
        MD_FORCE  = 2'b01,
        MD_PRED   = 2'b10,
        MD_PREDN  = 2'b11
    } shf_mode_e;

    typedef struct packed {
        logic    legal;
        logic    half;
        logic    signed_l;
        logic    round;
        logic    sat;
        logic    use_pred;
        logic    pred_inv;
        shf_op_e op;
    } shf_ctrl_t;

    function automatic logic in_range(input logic [IDX_W-1:0] v,
                                      input logic [IDX_W-1:0] lo,
                                      input logic [IDX_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
    import shf_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       op,
    input  logic [1:0]       mode,
    input  logic             glb_round,
    input  logic             glb_sat,
    output shf_ctrl_t        ctrl
);

    shf_mode_e md;
    assign md = shf_mode_e'(mode);

    always_comb begin
        ctrl    = '0;
        ctrl.op = shf_op_e'(op);
        if (in_range(idx, BYTE_FIRST, BYTE_LAST)) begin
            ctrl.legal    = 1'b1;
            ctrl.half     = 1'b0;
            ctrl.signed_l = (idx < BYTE_U_FIRST);
        end else if (in_range(idx, HALF_FIRST, HALF_LAST)) begin
            ctrl.legal    = 1'b1;
            ctrl.half     = 1'b1;
            ctrl.signed_l = (idx < HALF_U_FIRST);
        end
        if (ctrl.op == OP_RSV) begin
            ctrl.legal = 1'b0;
        end
        ctrl.round    = (md == MD_FORCE) ? 1'b1 : glb_round;
        ctrl.sat      = (md == MD_FORCE) ? 1'b1 : glb_sat;
        ctrl.use_pred = (md == MD_PRED) || (md == MD_PREDN);
        ctrl.pred_inv = (md == MD_PREDN);
    end

endmodule

// File: rtl/shf_lane.sv
module shf_lane
    import shf_pkg::*;
#(
    parameter  int LW  = 8,
    localparam int SHW = $clog2(LW)
) (
    input  logic [LW-1:0]  a,
    input  logic [SHW-1:0] sh,
    input  shf_op_e        op,
    input  logic           is_signed,
    input  logic           round_en,
    input  logic           sat_en,
    output logic [LW-1:0]  y
);

    localparam logic [LW-1:0] S_MAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] S_MIN = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] U_MAX = {LW{1'b1}};

    logic signed [LW-1:0] a_s;
    logic signed [LW-1:0] sra_s;
    logic signed [LW-1:0] back_s;
    logic        [LW-1:0] srl_v;
    logic        [LW-1:0] shl_v;
    logic        [LW-1:0] back_v;
    logic        [LW-1:0] clamp_v;
    logic                 rnd_bit;
    logic                 lost;

    always_comb begin
        a_s     = a;
        sra_s   = a_s >>> sh;
        srl_v   = a >> sh;
        shl_v   = a << sh;
        rnd_bit = 1'b0;
        if (sh != '0) begin
            rnd_bit = a[sh - 1'b1];
        end
        back_s  = $signed(shl_v) >>> sh;
        back_v  = is_signed ? back_s : (shl_v >> sh);
        lost    = (back_v != a);
        if (is_signed) begin
            clamp_v = a[LW-1] ? S_MIN : S_MAX;
        end else begin
            clamp_v = U_MAX;
        end
        unique case (op)
            OP_SRA:  y = sra_s + LW'(round_en & rnd_bit);
            OP_SRL:  y = srl_v + LW'(round_en & rnd_bit);
            OP_SLL:  y = (sat_en && lost) ? clamp_v : shl_v;
            default: y = a;
        endcase

        if (sh == '0) begin
            p_zero_shift_r11: assert (y == a);
        end
        if (op == OP_SLL && sat_en && is_signed) begin
            p_sat_sign_r5: assert (y[LW-1] == a[LW-1]);
        end
    end

endmodule

// File: rtl/shf_merge.sv
module shf_merge
    import shf_pkg::*;
#(
    parameter  int W   = DATA_W,
    localparam int NB  = W / BYTE_W,
    localparam int NH  = W / HALF_W
) (
    input  logic         legal,
    input  logic         half,
    input  logic         use_pred,
    input  logic         pred_inv,
    input  logic [W-1:0] pred,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] old_val,
    output logic [W-1:0] out_val
);

    logic [W-1:0] mask_b;
    logic [W-1:0] mask_h;
    logic [W-1:0] mask;

    for (genvar g = 0; g < NB; g++) begin : g_bmask
        assign mask_b[g*BYTE_W +: BYTE_W] =
            {BYTE_W{!use_pred || (pred[g*BYTE_W] ^ pred_inv)}};
    end
    for (genvar g = 0; g < NH; g++) begin : g_hmask
        assign mask_h[g*HALF_W +: HALF_W] =
            {HALF_W{!use_pred || (pred[g*HALF_W] ^ pred_inv)}};
    end

    assign mask    = half ? mask_h : mask_b;
    assign out_val = legal ? ((new_val & mask) | (old_val & ~mask)) : old_val;

endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
    import shf_pkg::*;
#(
    parameter  int W     = DATA_W,
    localparam int NB    = W / BYTE_W,
    localparam int NH    = W / HALF_W,
    localparam int SH_B  = $clog2(BYTE_W),
    localparam int SH_H  = $clog2(HALF_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic             use_imm,
    input  logic [AMT_W-1:0] imm8,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [W-1:0]     src_val,
    input  logic [W-1:0]     amt_val,
    input  logic [1:0]       mode,
    input  logic [W-1:0]     pred,
    input  logic             glb_round,
    input  logic             glb_sat,
    input  logic [W-1:0]     old_dst,
    output logic             out_valid,
    output logic [W-1:0]     result
);

    shf_ctrl_t        ctrl;
    logic [AMT_W-1:0] amt_raw;
    logic [W-1:0]     res_b;
    logic [W-1:0]     res_h;
    logic [W-1:0]     shifted;
    logic [W-1:0]     merged;

    shf_ctrl u_ctrl (
        .idx       (src_idx),
        .op        (op_sel),
        .mode      (mode),
        .glb_round (glb_round),
        .glb_sat   (glb_sat),
        .ctrl      (ctrl)
    );

    assign amt_raw = use_imm ? imm8 : amt_val[AMT_W-1:0];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        shf_lane #(.LW(BYTE_W)) u_lane (
            .a         (src_val[g*BYTE_W +: BYTE_W]),
            .sh        (amt_raw[SH_B-1:0]),
            .op        (ctrl.op),
            .is_signed (ctrl.signed_l),
            .round_en  (ctrl.round),
            .sat_en    (ctrl.sat),
            .y         (res_b[g*BYTE_W +: BYTE_W])
        );
    end

    for (genvar g = 0; g < NH; g++) begin : g_half
        shf_lane #(.LW(HALF_W)) u_lane (
            .a         (src_val[g*HALF_W +: HALF_W]),
            .sh        (amt_raw[SH_H-1:0]),
            .op        (ctrl.op),
            .is_signed (ctrl.signed_l),
            .round_en  (ctrl.round),
            .sat_en    (ctrl.sat),
            .y         (res_h[g*HALF_W +: HALF_W])
        );
    end

    assign shifted = ctrl.half ? res_h : res_b;

    shf_merge #(.W(W)) u_merge (
        .legal    (ctrl.legal),
        .half     (ctrl.half),
        .use_pred (ctrl.use_pred),
        .pred_inv (ctrl.pred_inv),
        .pred     (pred),
        .new_val  (shifted),
        .old_val  (old_dst),
        .out_val  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= merged;
            end
        end
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    p_reserved_op_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11) |=> (result == $past(old_dst)));

    p_pred_none_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10 && pred == '0) |=> (result == $past(old_dst)));

endmodule

// File: tb/sim_simd_lane_shifter.sv
module sim_simd_lane_shifter;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic        ui;
        logic [7:0]  imm;
        logic [4:0]  idx;
        logic [31:0] src;
        logic [31:0] amt;
        logic [1:0]  mode;
        logic [31:0] pred;
        logic        gr;
        logic        gs;
        logic [31:0] old;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // R2 arithmetic right, signed bytes
        '{2'b00,1'b0,8'h00,5'd3, 32'h807FF010,32'd2,2'b00,32'h0,1'b0,1'b0,32'h0,32'hE01FFC04,8'd2},
        // R2 logical right
        '{2'b01,1'b0,8'h00,5'd3, 32'h807FF010,32'd2,2'b00,32'h0,1'b0,1'b0,32'h0,32'h201F3C04,8'd2},
        // R2 logical left wraps without saturation
        '{2'b10,1'b0,8'h00,5'd9, 32'h01203FFF,32'd3,2'b00,32'h0,1'b0,1'b0,32'h0,32'h0800F8F8,8'd2},
        // R3 immediate, 20 mod 16 = 4, register amount ignored
        '{2'b00,1'b1,8'h14,5'd17,32'h80001234,32'd0,2'b00,32'h0,1'b0,1'b0,32'h0,32'hF8000123,8'd3},
        // R3 register amount 9 mod 8 = 1, immediate ignored
        '{2'b01,1'b0,8'h03,5'd10,32'h804002FF,32'd9,2'b00,32'h0,1'b0,1'b0,32'h0,32'h4020017F,8'd3},
        // R4 forced rounding arithmetic right
        '{2'b00,1'b0,8'h00,5'd4, 32'h0605FBFA,32'd2,2'b01,32'h0,1'b0,1'b0,32'h0,32'h0201FFFF,8'd4},
        // R6 global rounding on, logical right halves
        '{2'b01,1'b1,8'h01,5'd25,32'h0003FFFF,32'd0,2'b00,32'h0,1'b1,1'b0,32'h0,32'h00028000,8'd6},
        // R6 global rounding off
        '{2'b01,1'b1,8'h01,5'd25,32'h0003FFFF,32'd0,2'b00,32'h0,1'b0,1'b0,32'h0,32'h00017FFF,8'd6},
        // R5 forced signed saturation
        '{2'b10,1'b0,8'h00,5'd5, 32'h20E01FC0,32'd2,2'b01,32'h0,1'b0,1'b0,32'h0,32'h7F807C80,8'd5},
        // R5 global unsigned saturation, halves
        '{2'b10,1'b0,8'h00,5'd26,32'h0FFF1000,32'd4,2'b00,32'h0,1'b0,1'b1,32'h0,32'hFFF0FFFF,8'd5},
        // R7 predicate mode 10
        '{2'b01,1'b0,8'h00,5'd6, 32'h80808080,32'd1,2'b10,32'h0001FE01,1'b0,1'b0,32'hAABBCCDD,32'hAA40CC40,8'd7},
        // R7 complemented predicate mode 11
        '{2'b01,1'b0,8'h00,5'd6, 32'h80808080,32'd1,2'b11,32'h0001FE01,1'b0,1'b0,32'hAABBCCDD,32'h40BB40DD,8'd7},
        // R7 halves predicated
        '{2'b10,1'b0,8'h00,5'd20,32'h00010001,32'd1,2'b10,32'h00000001,1'b0,1'b0,32'h11112222,32'h11110002,8'd7},
        // R8 index 1 illegal
        '{2'b00,1'b0,8'h00,5'd1, 32'h12345678,32'd1,2'b00,32'h0,1'b0,1'b0,32'hDEADBEEF,32'hDEADBEEF,8'd8},
        // R8 index 30 illegal
        '{2'b00,1'b0,8'h00,5'd30,32'h12345678,32'd1,2'b00,32'h0,1'b0,1'b0,32'hDEADBEEF,32'hDEADBEEF,8'd8},
        // R8 reserved opcode
        '{2'b11,1'b0,8'h00,5'd3, 32'h12345678,32'd1,2'b00,32'h0,1'b0,1'b0,32'h0BADF00D,32'h0BADF00D,8'd8},
        // R11 byte amount 8 wraps to 0, saturation forced
        '{2'b10,1'b0,8'h00,5'd2, 32'h807FFF01,32'd8,2'b01,32'h0,1'b0,1'b0,32'h0,32'h807FFF01,8'd11},
        // R11 half amount 16 wraps to 0, rounding forced
        '{2'b00,1'b0,8'h00,5'd18,32'h807FFF01,32'd16,2'b01,32'h0,1'b0,1'b0,32'h0,32'h807FFF01,8'd11},
        // R2 arithmetic right on an unsigned bank still sign-fills
        '{2'b00,1'b0,8'h00,5'd12,32'hF0807F00,32'd4,2'b00,32'h0,1'b0,1'b0,32'h0,32'hFFF80700,8'd2},
        // R5 saturation has no effect on right shift
        '{2'b00,1'b0,8'h00,5'd3, 32'h00000003,32'd1,2'b00,32'h0,1'b0,1'b1,32'h0,32'h00000001,8'd5},
        // R6 mode 10 uses global saturation, all lanes enabled
        '{2'b10,1'b0,8'h00,5'd8, 32'h80808080,32'd1,2'b10,32'h01010101,1'b0,1'b1,32'h0,32'hFFFFFFFF,8'd6},
        // R6 mode 00 with saturation off wraps
        '{2'b10,1'b0,8'h00,5'd8, 32'h80808080,32'd1,2'b00,32'h0,1'b0,1'b0,32'h0,32'h00000000,8'd6},
        // R7 with R4: complemented predicate plus global rounding
        '{2'b00,1'b0,8'h00,5'd4, 32'h03030303,32'd1,2'b11,32'h00010001,1'b1,1'b0,32'h11223344,32'h02220244,8'd7},
        // R1 index 23 is still signed halves
        '{2'b00,1'b0,8'h00,5'd23,32'h8002FFFF,32'd1,2'b00,32'h0,1'b0,1'b0,32'h0,32'hC001FFFF,8'd1},
        // R1 index 15 is unsigned bytes
        '{2'b01,1'b0,8'h00,5'd15,32'hF0F0F0F0,32'd4,2'b00,32'h0,1'b0,1'b0,32'h0,32'h0F0F0F0F,8'd1},
        // R1 index 29 is halves, amount 15
        '{2'b10,1'b0,8'h00,5'd29,32'h00010003,32'd15,2'b00,32'h0,1'b0,1'b0,32'h0,32'h80008000,8'd1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op_sel;
    logic        use_imm;
    logic [7:0]  imm8;
    logic [4:0]  src_idx;
    logic [31:0] src_val;
    logic [31:0] amt_val;
    logic [1:0]  mode;
    logic [31:0] pred;
    logic        glb_round;
    logic        glb_sat;
    logic [31:0] old_dst;
    logic        out_valid;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_lane_shifter u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .use_imm   (use_imm),
        .imm8      (imm8),
        .src_idx   (src_idx),
        .src_val   (src_val),
        .amt_val   (amt_val),
        .mode      (mode),
        .pred      (pred),
        .glb_round (glb_round),
        .glb_sat   (glb_sat),
        .old_dst   (old_dst),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        op_sel    = v.op;
        use_imm   = v.ui;
        imm8      = v.imm;
        src_idx   = v.idx;
        src_val   = v.src;
        amt_val   = v.amt;
        mode      = v.mode;
        pred      = v.pred;
        glb_round = v.gr;
        glb_sat   = v.gs;
        old_dst   = v.old;
    endtask

    initial begin
        logic [31:0] held;
        rst      = 1'b1;
        in_valid = 1'b0;
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R10 result in reset", result, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R9 no request yet: out_valid stays low
        check("R9 idle out_valid", {31'b0, out_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
            check("R9 out_valid after request", {31'b0, out_valid}, 32'h1);
        end

        // R9 hold: no request, change inputs, result must not move
        held     = result;
        in_valid = 1'b0;
        apply(VECS[1]);
        @(negedge clk);
        check("R9 out_valid falls", {31'b0, out_valid}, 32'h0);
        check("R9 result held", result, held);
        @(negedge clk);
        check("R9 result still held", result, held);

        // R10 reset after activity clears state
        rst = 1'b1;
        @(negedge clk);
        check("R10 result cleared", result, 32'h0);
        check("R10 out_valid cleared", {31'b0, out_valid}, 32'h0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule